// File: doc/BRIEF.md
# Length-Framed Packet Engine with Dual-Seed CRC16

This block turns a payload byte stream into framed packets and turns received framed bytes back into payload. The transmit side takes a start request with a length. It emits two marker beats, then the length byte, then the payload taken from an upstream valid/ready stream. When checking is enabled it appends a 16-bit CRC. The receive side is armed by a one-cycle marker-detected event. It captures the next byte as the length and forwards that many payload bytes downstream. It then consumes the CRC field when checking is enabled, and reports end of packet together with the CRC verdict.

The CRC starting value is programmable. The transmitter computes its CRC from the configured seed or from a zero seed, chosen per packet. The receiver runs two accumulators side by side, one from each seed, and accepts the packet if either result equals the received field. Packets carry at most 40 payload bytes. A longer length is refused on transmit and aborts reception on receive.

Each stream follows valid/ready rules. A beat transfers on a clock edge where both valid and ready are high. A source that raises valid keeps it high, with its data unchanged, until the transfer happens. On transmit, upstream payload is accepted only while the output side is ready, so downstream back-pressure reaches the payload source. On receive, the incoming byte is held off while a payload byte cannot be delivered downstream. Length and CRC bytes are always accepted.

Top module: `pkt_engine`

## Requirements
- R1: After reset, tx_busy, tx_out_valid, rx_out_valid, rx_done, rx_crc_ok and rx_len_err are 0 and rx_len is 0.
- R2: A transmitted packet is, in order: 8'hA5 and 8'h3C with tx_out_mark high, then the length byte, then the payload bytes in arrival order, then (when cfg_crc_en was high at start) the CRC high byte and then the CRC low byte. tx_out_mark is low for every beat after the two marker beats.
- R3: The transmitted CRC covers only the payload. It is computed LSB-first, one right shift per data bit, XORing the reflected polynomial constant 16'hA001 (x^16+x^15+x^2+1) whenever the outgoing bit differs from the data bit. It starts from cfg_seed, or from 16'h0000 when cfg_tx_zero_seed is high. Seed and mode are sampled at the accepted start.
- R4: While tx_out_valid is high and tx_out_ready is low, the output beat stays unchanged. tx_in_ready is high only during the payload phase and only while tx_out_ready is high.
- R5: tx_start is accepted only when tx_busy is low and tx_len is at most 40. tx_busy rises in the cycle after an accepted start and falls in the cycle after the final beat transfers. A start that is not accepted has no effect on the output.
- R6: After rx_mark, the next accepted byte is the length. The following length-many accepted bytes appear on rx_out_data in order.
- R7: rx_done is a one-cycle pulse in the cycle after the final expected byte is accepted (length payload bytes, plus 2 when CRC is enabled). rx_len then holds the captured length, and no pulse appears earlier.
- R8: With rx_done, rx_crc_ok is 1 when the received field (high byte first) equals the payload CRC from cfg_seed or from zero, and 0 otherwise. It is also 0 when CRC was disabled at the marker.
- R9: A length byte above 40 gives a one-cycle rx_len_err pulse in the next cycle and no rx_done. Bytes after it are dropped without output until the next marker.
- R10: rx_mark restarts framing in any state. The packet in progress is abandoned without rx_done.
- R11: Bytes arriving with no preceding marker are accepted and dropped, with no payload output and no rx_done.
- R12: In the receive payload phase, rx_in_ready follows rx_out_ready, so an undeliverable byte is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_crc_en | input | 1 | Append/check CRC16 |
| cfg_seed | input | 16 | Programmable CRC seed |
| cfg_tx_zero_seed | input | 1 | Transmit CRC uses zero seed |
| tx_start | input | 1 | Start request for a transmit packet |
| tx_len | input | 8 | Payload length for the start request |
| tx_busy | output | 1 | Transmit packet in progress |
| tx_in_valid | input | 1 | Payload byte valid |
| tx_in_ready | output | 1 | Payload byte accepted |
| tx_in_data | input | 8 | Payload byte |
| tx_out_valid | output | 1 | Framed beat valid |
| tx_out_ready | input | 1 | Downstream accepts framed beat |
| tx_out_data | output | 8 | Framed beat |
| tx_out_mark | output | 1 | Beat is a marker symbol |
| rx_mark | input | 1 | Marker-detected event |
| rx_in_valid | input | 1 | Received byte valid |
| rx_in_ready | output | 1 | Received byte accepted |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Payload byte valid |
| rx_out_ready | input | 1 | Buffer accepts payload byte |
| rx_out_data | output | 8 | Payload byte |
| rx_done | output | 1 | End-of-packet pulse |
| rx_crc_ok | output | 1 | CRC verdict, valid with rx_done |
| rx_len_err | output | 1 | Oversize length pulse |
| rx_len | output | 8 | Last captured length |

## Verification
A corrupted byte counter shows up in the first packet. The CRC beats appear one beat early or late on transmit, or rx_done pulses at the wrong byte on receive. A wrong accumulator update or seed load shows up as a mismatching CRC beat, or a wrong rx_crc_ok, at the end of that same packet. The sweep covers every legal length with CRC on and off, both seeds and a corrupted field, so each of these faults is visible within a few dozen cycles of a packet end. A mishandled stall shows up as a skipped or duplicated payload byte under the irregular ready patterns.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_R = 16'hA001;

  typedef enum logic [2:0] {
    TX_IDLE, TX_MK0, TX_MK1, TX_LEN, TX_PAY, TX_CRCH, TX_CRCL
  } tx_st_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_LEN, RX_PAY, RX_CRCH, RX_CRCL
  } rx_st_t;
endpackage

// File: rtl/crc16_acc.sv
module crc16_acc #(
  parameter int W  = 16,
  parameter int DW = 8,
  parameter logic [W-1:0] POLY = 16'hA001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  seed,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [W-1:0]  crc
);
  logic [W-1:0] crc_q;
  logic [W-1:0] nxt;

  // one shift per data bit, least significant bit first
  always_comb begin
    nxt = crc_q;
    for (int i = 0; i < DW; i++) begin
      if (nxt[0] ^ din[i]) nxt = (nxt >> 1) ^ POLY;
      else                 nxt = nxt >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= '0;
    else if (load) crc_q <= seed;
    else if (en)   crc_q <= nxt;
  end

  assign crc = crc_q;
endmodule

// File: rtl/pkt_tx.sv
module pkt_tx
  import pkt_pkg::*;
#(
  parameter int MAX_LEN = 40,
  parameter int LEN_W   = BYTE_W,
  parameter logic [BYTE_W-1:0] MARK0 = 8'hA5,
  parameter logic [BYTE_W-1:0] MARK1 = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_crc_en,
  input  logic [CRC_W-1:0]  cfg_seed,
  input  logic              cfg_tx_zero_seed,
  input  logic              tx_start,
  input  logic [LEN_W-1:0]  tx_len,
  output logic              tx_busy,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [BYTE_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [BYTE_W-1:0] tx_out_data,
  output logic              tx_out_mark
);
  tx_st_t             st;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]   cnt;
  logic               crc_on;
  logic [CRC_W-1:0]   crc;
  logic               start_ok;
  logic               out_hs;
  logic               pay_hs;

  assign start_ok = tx_start && (st == TX_IDLE) && (tx_len <= LEN_W'(MAX_LEN));
  assign out_hs   = tx_out_valid && tx_out_ready;
  assign pay_hs   = (st == TX_PAY) && out_hs;

  crc16_acc #(.W(CRC_W), .DW(BYTE_W), .POLY(CRC_POLY_R)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_ok),
    .seed  (cfg_tx_zero_seed ? '0 : cfg_seed),
    .en    (pay_hs),
    .din   (tx_in_data),
    .crc   (crc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= TX_IDLE;
      len_q  <= '0;
      cnt    <= '0;
      crc_on <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: if (start_ok) begin
          st     <= TX_MK0;
          len_q  <= tx_len;
          cnt    <= '0;
          crc_on <= cfg_crc_en;
        end
        TX_MK0: if (out_hs) st <= TX_MK1;
        TX_MK1: if (out_hs) st <= TX_LEN;
        TX_LEN: if (out_hs) begin
          if (len_q != '0) st <= TX_PAY;
          else             st <= crc_on ? TX_CRCH : TX_IDLE;
        end
        TX_PAY: if (out_hs) begin
          cnt <= cnt + LEN_W'(1);
          if ((cnt + LEN_W'(1)) == len_q) st <= crc_on ? TX_CRCH : TX_IDLE;
        end
        TX_CRCH: if (out_hs) st <= TX_CRCL;
        TX_CRCL: if (out_hs) st <= TX_IDLE;
        default: st <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    tx_out_data = '0;
    case (st)
      TX_MK0:  tx_out_data = MARK0;
      TX_MK1:  tx_out_data = MARK1;
      TX_LEN:  tx_out_data = BYTE_W'(len_q);
      TX_PAY:  tx_out_data = tx_in_data;
      TX_CRCH: tx_out_data = crc[CRC_W-1 -: BYTE_W];
      TX_CRCL: tx_out_data = crc[BYTE_W-1:0];
      default: tx_out_data = '0;
    endcase
  end

  assign tx_busy      = (st != TX_IDLE);
  assign tx_out_mark  = (st == TX_MK0) || (st == TX_MK1);
  assign tx_out_valid = (st == TX_PAY) ? tx_in_valid : tx_busy;
  assign tx_in_ready  = (st == TX_PAY) && tx_out_ready;
endmodule

// File: rtl/pkt_rx.sv
module pkt_rx
  import pkt_pkg::*;
#(
  parameter int MAX_LEN = 40,
  parameter int LEN_W   = BYTE_W,
  parameter int NSEED   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_crc_en,
  input  logic [CRC_W-1:0]  cfg_seed,
  input  logic              rx_mark,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [BYTE_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [BYTE_W-1:0] rx_out_data,
  output logic              rx_done,
  output logic              rx_crc_ok,
  output logic              rx_len_err,
  output logic [LEN_W-1:0]  rx_len
);
  rx_st_t             st;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]   cnt;
  logic               crc_on;
  logic [BYTE_W-1:0]  hi_q;
  logic               done_q, ok_q, lerr_q;
  logic               in_hs;
  logic               len_hs;
  logic               pay_hs;
  logic [CRC_W-1:0]   seed_v [NSEED];
  logic [CRC_W-1:0]   acc    [NSEED];
  logic [NSEED-1:0]   hit;
  logic [LEN_W-1:0]   in_len;

  assign rx_in_ready  = (st != RX_PAY) || rx_out_ready;
  assign in_hs        = rx_in_valid && rx_in_ready;
  assign len_hs       = (st == RX_LEN) && in_hs && !rx_mark;
  assign pay_hs       = (st == RX_PAY) && in_hs && !rx_mark;
  assign in_len       = LEN_W'(rx_in_data);

  // seed 0 is the programmed value; any further slots start from zero
  generate
    for (genvar g = 0; g < NSEED; g++) begin : g_acc
      if (g == 0) begin : g_cfg
        assign seed_v[g] = cfg_seed;
      end else begin : g_zero
        assign seed_v[g] = '0;
      end
      crc16_acc #(.W(CRC_W), .DW(BYTE_W), .POLY(CRC_POLY_R)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (len_hs),
        .seed  (seed_v[g]),
        .en    (pay_hs),
        .din   (rx_in_data),
        .crc   (acc[g])
      );
      assign hit[g] = ({hi_q, rx_in_data} == acc[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      len_q  <= '0;
      cnt    <= '0;
      crc_on <= 1'b0;
      hi_q   <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      lerr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      lerr_q <= 1'b0;
      if (rx_mark) begin
        st     <= RX_LEN;
        crc_on <= cfg_crc_en;
      end else begin
        case (st)
          RX_LEN: if (in_hs) begin
            len_q <= in_len;
            cnt   <= '0;
            if (in_len > LEN_W'(MAX_LEN)) begin
              lerr_q <= 1'b1;
              st     <= RX_IDLE;
            end else if (in_len != '0) begin
              st <= RX_PAY;
            end else if (crc_on) begin
              st <= RX_CRCH;
            end else begin
              done_q <= 1'b1;
              st     <= RX_IDLE;
            end
          end
          RX_PAY: if (in_hs) begin
            cnt <= cnt + LEN_W'(1);
            if ((cnt + LEN_W'(1)) == len_q) begin
              if (crc_on) st <= RX_CRCH;
              else begin
                done_q <= 1'b1;
                st     <= RX_IDLE;
              end
            end
          end
          RX_CRCH: if (in_hs) begin
            hi_q <= rx_in_data;
            st   <= RX_CRCL;
          end
          RX_CRCL: if (in_hs) begin
            done_q <= 1'b1;
            ok_q   <= |hit;
            st     <= RX_IDLE;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assign rx_out_valid = (st == RX_PAY) && rx_in_valid && !rx_mark;
  assign rx_out_data  = rx_in_data;
  assign rx_done      = done_q;
  assign rx_crc_ok    = ok_q;
  assign rx_len_err   = lerr_q;
  assign rx_len       = len_q;
endmodule

// File: rtl/pkt_engine.sv
module pkt_engine
  import pkt_pkg::*;
#(
  parameter int MAX_LEN = 40,
  parameter logic [7:0] MARK0 = 8'hA5,
  parameter logic [7:0] MARK1 = 8'h3C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_crc_en,
  input  logic [15:0] cfg_seed,
  input  logic        cfg_tx_zero_seed,
  input  logic        tx_start,
  input  logic [7:0]  tx_len,
  output logic        tx_busy,
  input  logic        tx_in_valid,
  output logic        tx_in_ready,
  input  logic [7:0]  tx_in_data,
  output logic        tx_out_valid,
  input  logic        tx_out_ready,
  output logic [7:0]  tx_out_data,
  output logic        tx_out_mark,
  input  logic        rx_mark,
  input  logic        rx_in_valid,
  output logic        rx_in_ready,
  input  logic [7:0]  rx_in_data,
  output logic        rx_out_valid,
  input  logic        rx_out_ready,
  output logic [7:0]  rx_out_data,
  output logic        rx_done,
  output logic        rx_crc_ok,
  output logic        rx_len_err,
  output logic [7:0]  rx_len
);
  pkt_tx #(.MAX_LEN(MAX_LEN), .LEN_W(BYTE_W), .MARK0(MARK0), .MARK1(MARK1)) u_tx (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_crc_en       (cfg_crc_en),
    .cfg_seed         (cfg_seed),
    .cfg_tx_zero_seed (cfg_tx_zero_seed),
    .tx_start         (tx_start),
    .tx_len           (tx_len),
    .tx_busy          (tx_busy),
    .tx_in_valid      (tx_in_valid),
    .tx_in_ready      (tx_in_ready),
    .tx_in_data       (tx_in_data),
    .tx_out_valid     (tx_out_valid),
    .tx_out_ready     (tx_out_ready),
    .tx_out_data      (tx_out_data),
    .tx_out_mark      (tx_out_mark)
  );

  pkt_rx #(.MAX_LEN(MAX_LEN), .LEN_W(BYTE_W), .NSEED(2)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_crc_en   (cfg_crc_en),
    .cfg_seed     (cfg_seed),
    .rx_mark      (rx_mark),
    .rx_in_valid  (rx_in_valid),
    .rx_in_ready  (rx_in_ready),
    .rx_in_data   (rx_in_data),
    .rx_out_valid (rx_out_valid),
    .rx_out_ready (rx_out_ready),
    .rx_out_data  (rx_out_data),
    .rx_done      (rx_done),
    .rx_crc_ok    (rx_crc_ok),
    .rx_len_err   (rx_len_err),
    .rx_len       (rx_len)
  );
endmodule

// File: rtl/pkt_engine_chk.sv
module pkt_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_start,
  input logic       tx_busy,
  input logic       tx_out_valid,
  input logic       tx_out_ready,
  input logic [7:0] tx_out_data,
  input logic       tx_out_mark,
  input logic       rx_in_ready,
  input logic       rx_out_valid,
  input logic       rx_out_ready,
  input logic       rx_done,
  input logic       rx_crc_ok,
  input logic       rx_len_err
);
  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_data) && $stable(tx_out_mark));

  // R5
  tx_busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_start));

  // R2
  tx_valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid |-> tx_busy);

  // R7
  rx_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R7
  rx_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && rx_len_err));

  // R8
  rx_ok_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_crc_ok |-> rx_done);

  // R9
  rx_lerr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_len_err |=> !rx_out_valid);

  // R12
  rx_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready |-> !rx_in_ready);
endmodule

bind pkt_engine pkt_engine_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_start     (tx_start),
  .tx_busy      (tx_busy),
  .tx_out_valid (tx_out_valid),
  .tx_out_ready (tx_out_ready),
  .tx_out_data  (tx_out_data),
  .tx_out_mark  (tx_out_mark),
  .rx_in_ready  (rx_in_ready),
  .rx_out_valid (rx_out_valid),
  .rx_out_ready (rx_out_ready),
  .rx_done      (rx_done),
  .rx_crc_ok    (rx_crc_ok),
  .rx_len_err   (rx_len_err)
);

// File: tb/pkt_engine_tb_top.sv
`timescale 1ns/1ps
module pkt_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_crc_en = 1'b0;
  logic [15:0] cfg_seed = '0;
  logic        cfg_tx_zero_seed = 1'b0;
  logic        tx_start = 1'b0;
  logic [7:0]  tx_len = '0;
  logic        tx_busy;
  logic        tx_in_valid = 1'b0;
  logic        tx_in_ready;
  logic [7:0]  tx_in_data = '0;
  logic        tx_out_valid;
  logic        tx_out_ready = 1'b0;
  logic [7:0]  tx_out_data;
  logic        tx_out_mark;
  logic        rx_mark = 1'b0;
  logic        rx_in_valid = 1'b0;
  logic        rx_in_ready;
  logic [7:0]  rx_in_data = '0;
  logic        rx_out_valid;
  logic        rx_out_ready = 1'b0;
  logic [7:0]  rx_out_data;
  logic        rx_done;
  logic        rx_crc_ok;
  logic        rx_len_err;
  logic [7:0]  rx_len;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  logic [7:0] pbuf [0:63];
  logic [7:0] sbuf [0:63];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pkt_engine dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit pat(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return (c % 3) != 0;
      default: return (c % 5) < 2;
    endcase
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] s, input int n);
    logic [15:0] c = s;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ pbuf[k][b]) ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    return c;
  endfunction

  task automatic fill(input int len, input logic [15:0] seed);
    for (int i = 0; i < 64; i++) pbuf[i] = 8'(i * 37 + len * 11) ^ seed[7:0];
  endtask

  task automatic tx_pkt(input int len, input bit ce, input bit zs, input logic [15:0] seed,
                        input int bp, input bit interfere);
    logic [7:0] ebuf [0:47];
    logic [15:0] c;
    int total, oidx, pidx, it, bad_rdy;
    bit took;
    fill(len, seed);
    c = ref_crc(zs ? 16'h0 : seed, len);
    ebuf[0] = 8'hA5; ebuf[1] = 8'h3C; ebuf[2] = 8'(len);
    for (int i = 0; i < len; i++) ebuf[3+i] = pbuf[i];
    ebuf[3+len] = c[15:8]; ebuf[4+len] = c[7:0];
    total = 3 + len + (ce ? 2 : 0);
    @(negedge clk);
    cfg_crc_en = ce; cfg_tx_zero_seed = zs; cfg_seed = seed;
    tx_start = 1'b1; tx_len = 8'(len);
    @(negedge clk);
    tx_start = 1'b0;
    cfg_seed = ~seed; cfg_tx_zero_seed = ~zs;
    chk(tx_busy == 1'b1, "R5", "busy after start", int'(tx_busy), 1);
    oidx = 0; pidx = 0; it = 0; bad_rdy = 0; took = 1'b0;
    while (oidx < total && it < 2000) begin
      if (took) tx_in_valid = 1'b0;
      took = 1'b0;
      tx_out_ready = pat(bp, cyc);
      if (!tx_in_valid && pidx < len && pat((bp + 1) % 3, cyc)) begin
        tx_in_valid = 1'b1; tx_in_data = pbuf[pidx];
      end
      tx_start = interfere && (it == 4);
      tx_len = 8'd7;
      #1;
      if (tx_in_ready && !(oidx >= 3 && oidx < 3 + len)) bad_rdy++;
      if (tx_out_valid && tx_out_ready) begin
        if (oidx >= 3 + len)
          chk(tx_out_data == ebuf[oidx] && !tx_out_mark, "R3", "crc beat", int'(tx_out_data), int'(ebuf[oidx]));
        else
          chk(tx_out_data == ebuf[oidx] && tx_out_mark == (oidx < 2), "R2", "frame beat",
              int'({tx_out_mark, tx_out_data}), int'({oidx < 2, ebuf[oidx]}));
        oidx++;
      end
      if (tx_in_valid && tx_in_ready) begin pidx++; took = 1'b1; end
      it++;
      @(negedge clk);
    end
    tx_in_valid = 1'b0; tx_start = 1'b0; tx_out_ready = 1'b0;
    chk(oidx == total, "R2", "beat count", oidx, total);
    chk(bad_rdy == 0, "R4", "in_ready outside payload", bad_rdy, 0);
    chk(tx_busy == 1'b0, "R5", "busy after last beat", int'(tx_busy), 0);
  endtask

  task automatic rx_pkt(input int lenb, input bit ce, input logic [15:0] seed, input int mode, input int bp);
    logic [15:0] cs, cz, fld;
    bit ok_valid, exp_ok, took;
    int len, n, sidx, ridx, it, early, extra, bp_bad;
    ok_valid = (lenb <= 40);
    len = ok_valid ? lenb : 0;
    fill(lenb, seed);
    cs = ref_crc(seed, len);
    cz = ref_crc(16'h0, len);
    fld = (mode == 0) ? cs : (mode == 1) ? cz : (cs ^ 16'h0100);
    if (mode == 2 && fld == cz) fld = fld ^ 16'h0001;
    exp_ok = ce && (mode != 2);
    sbuf[0] = 8'(lenb);
    if (ok_valid) begin
      for (int i = 0; i < len; i++) sbuf[1+i] = pbuf[i];
      sbuf[1+len] = fld[15:8]; sbuf[2+len] = fld[7:0];
      n = 1 + len + (ce ? 2 : 0);
    end else begin
      sbuf[1] = 8'h11; sbuf[2] = 8'h22; sbuf[3] = 8'h33;
      n = 4;
    end
    @(negedge clk);
    cfg_crc_en = ce; cfg_seed = seed; rx_mark = 1'b1;
    @(negedge clk);
    rx_mark = 1'b0;
    sidx = 0; ridx = 0; it = 0; early = 0; extra = 0; bp_bad = 0; took = 1'b0;
    while (sidx < n && it < 3000) begin
      if (took) rx_in_valid = 1'b0;
      took = 1'b0;
      rx_out_ready = pat(bp, cyc);
      if (!rx_in_valid && pat((bp + 2) % 3, cyc)) begin
        rx_in_valid = 1'b1; rx_in_data = sbuf[sidx];
      end
      #1;
      if (rx_done) early++;
      if (rx_out_valid && !rx_out_ready && rx_in_ready) bp_bad++;
      if (rx_out_valid && rx_out_ready) begin
        if (!ok_valid || ridx >= len) extra++;
        else chk(rx_out_data == pbuf[ridx], "R6", "payload byte", int'(rx_out_data), int'(pbuf[ridx]));
        ridx++;
      end
      if (rx_in_valid && rx_in_ready) begin sidx++; took = 1'b1; end
      it++;
      @(negedge clk);
      if (took && sidx == 1 && !ok_valid)
        chk(rx_len_err == 1'b1, "R9", "length error pulse", int'(rx_len_err), 1);
    end
    rx_in_valid = 1'b0;
    chk(bp_bad == 0, "R12", "byte taken while stalled", bp_bad, 0);
    chk(extra == 0, "R6", "extra payload bytes", extra, 0);
    if (ok_valid) begin
      chk(rx_done == 1'b1, "R7", "done pulse", int'(rx_done), 1);
      chk(early == 0, "R7", "early done", early, 0);
      chk(rx_len == 8'(len), "R7", "captured length", int'(rx_len), len);
      chk(ridx == len, "R6", "payload count", ridx, len);
      chk(rx_crc_ok == exp_ok, "R8", "crc verdict", int'(rx_crc_ok), int'(exp_ok));
      @(negedge clk);
      chk(rx_done == 1'b0, "R7", "done one cycle", int'(rx_done), 0);
    end else begin
      chk(rx_done == 1'b0 && early == 0 && ridx == 0, "R9", "no output after error",
          int'(rx_done) + early + ridx, 0);
    end
    rx_out_ready = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] b, inout int nout, inout int ndone);
    rx_in_valid = 1'b1; rx_in_data = b; rx_out_ready = 1'b1;
    #1;
    if (rx_out_valid) nout++;
    @(negedge clk);
    rx_in_valid = 1'b0;
    if (rx_done) ndone++;
  endtask

  initial begin : watchdog
    while (cyc < 150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog run did not finish actual=%0d expected<%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin : main
    int nout, ndone;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!tx_busy && !tx_out_valid && !rx_out_valid, "R1", "tx/rx idle after reset",
        int'({tx_busy, tx_out_valid, rx_out_valid}), 0);
    chk(!rx_done && !rx_crc_ok && !rx_len_err && rx_len == 8'd0, "R1", "rx status after reset",
        int'({rx_done, rx_crc_ok, rx_len_err, rx_len}), 0);

    // R5 oversize start ignored
    tx_start = 1'b1; tx_len = 8'd41; tx_out_ready = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    chk(!tx_busy && !tx_out_valid, "R5", "oversize start ignored", int'({tx_busy, tx_out_valid}), 0);
    tx_out_ready = 1'b0;

    // R11 bytes without marker
    nout = 0; ndone = 0;
    for (int i = 0; i < 5; i++) rx_byte(8'(i + 3), nout, ndone);
    chk(nout == 0 && ndone == 0, "R11", "unframed bytes dropped", nout + ndone, 0);

    for (int len = 0; len <= 40; len++) begin
      for (int ce = 0; ce < 2; ce++) begin
        tx_pkt(len, ce[0], len[0], 16'h1D0F ^ 16'(len * 257), len % 3, len == 9);
        rx_pkt(len, ce[0], 16'hB3C5 ^ 16'(len * 771), len % 3, (len + 1) % 3);
      end
    end
    tx_pkt(5, 1'b1, 1'b0, 16'hFFFF, 1, 1'b0);
    rx_pkt(7, 1'b1, 16'h0000, 0, 0);

    // R9 oversize lengths
    rx_pkt(41, 1'b1, 16'h1234, 0, 0);
    rx_pkt(255, 1'b0, 16'h1234, 0, 1);

    // R10 restart mid packet
    @(negedge clk);
    cfg_crc_en = 1'b1; rx_mark = 1'b1;
    @(negedge clk);
    rx_mark = 1'b0;
    nout = 0; ndone = 0;
    rx_byte(8'd10, nout, ndone);
    for (int i = 0; i < 4; i++) rx_byte(8'(i), nout, ndone);
    chk(nout == 4 && ndone == 0, "R10", "partial packet before restart", nout * 16 + ndone, 64);
    rx_pkt(3, 1'b1, 16'h5A5A, 1, 0);
    chk(1'b1, "R10", "restart packet completed", 0, 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule